// File: doc/BRIEF.md
# Inter-Core Interrupt and Mailbox Send Engine

This block takes one 64-bit send command at a time and turns it into one or two 32-bit transactions on a request/acknowledge master port. Each transaction carries the 10-bit identity of the destination core and a 16-bit address inside that core's register space. Routing by core identity and the per-core registers themselves lie outside the block.

There are three kinds of command. An interrupt post writes a one-hot vector into the destination's interrupt-set register. A mailbox post writes one of the destination's mailbox words. A free-address post writes any 16-bit address. Mailbox and free-address posts carry a four-bit lane-keep mask. When any keep bit is set, the engine first reads the destination word, keeps the flagged bytes, replaces the others with the command's upper word, and writes the result back. When the mask is zero, the engine skips the read and writes the upper word whole.

Top module: `ipi_send_engine`

## Requirements
- R1: Every transaction of a command drives `bus_core` with command bits 25:16.
- R2: A command of kind 0 (interrupt post) issues exactly one write, with no read, of the value `1 << cmd_data[4:0]` to address 0x1008. The keep mask is ignored.
- R3: A command of kind 1 (mailbox post) addresses 0x1020 + (cmd_data[15:0] & 0x001C).
- R4: A command of kind 2 (free-address post) addresses cmd_data[15:0].
- R5: The keep mask is cmd_data[30:27], where bit n covers byte lane n (bits 8n+7:8n). In the merged write, a set bit keeps the byte that was read, and a clear bit takes the byte from cmd_data[63:32].
- R6: For kinds 1 and 2 with a non-zero keep mask, a read of the address comes first. After that read is acknowledged, a write to the same address and core follows.
- R7: For kinds 1 and 2 with a zero keep mask, the only transaction is a write of cmd_data[63:32].
- R8: A command of kind 1 or 2 with `cmd_wide` = 0 is accepted but causes no bus activity.
- R9: A command of kind 3 is accepted but causes no bus activity.
- R10: `cmd_ready` falls in the cycle after a command that produces bus activity is accepted. It stays low until the final write's acknowledge, and it is high again in the cycle after that.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_we`, `bus_addr`, `bus_core` and `bus_wdata` hold their values into the next cycle.
- R12: After reset, `cmd_ready` is 1 and `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_kind | input | 2 | 0 interrupt post, 1 mailbox post, 2 free-address post, 3 reserved |
| cmd_wide | input | 1 | Command arrived as a 64-bit access |
| cmd_data | input | 64 | Command word |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_core | output | 10 | Destination core identity |
| bus_addr | output | 16 | Address in the destination core's space |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction accepted; rdata valid for reads |
| bus_rdata | input | 32 | Read data |

## Verification
The hardest case to reach is the merge path while the responder stalls: a read must hold its request for several cycles, then return data whose bytes differ from the command's upper word in every lane. Only then does a wrong keep polarity or a wrong lane order show in the written word. The bench acts as the responder. It withholds the acknowledge for a chosen number of cycles, checking the held request on each one, and it returns old words with distinct bytes per lane under alternating keep masks, as well as an all-keep mask.

// File: rtl/ipi_send_pkg.sv
package ipi_send_pkg;

    localparam int CMD_W    = 64;
    localparam int DATA_W   = 32;
    localparam int CORE_W   = 10;
    localparam int ADDR_W   = 16;
    localparam int LANE_W   = 8;
    localparam int LANES    = DATA_W / LANE_W;
    localparam int VEC_W    = $clog2(DATA_W);

    localparam int CORE_LSB = 16;
    localparam int KEEP_LSB = 27;
    localparam int HI_LSB   = 32;

    localparam logic [ADDR_W-1:0] SET_REG_ADDR  = 16'h1008;
    localparam logic [ADDR_W-1:0] MBOX_BASE     = 16'h1020;
    localparam logic [ADDR_W-1:0] MBOX_SEL_BITS = 16'h001C;

    typedef enum logic [1:0] {
        KIND_IRQ  = 2'd0,
        KIND_MBOX = 2'd1,
        KIND_FREE = 2'd2,
        KIND_RSVD = 2'd3
    } send_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              launch;
        logic              need_read;
        logic [CORE_W-1:0] core;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  keep;
    } send_op_t;

    function automatic logic [DATA_W-1:0] vec_to_onehot(input logic [VEC_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_send_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic             wide,
    input  logic [CMD_W-1:0] cmd,
    output send_op_t         op
);

    logic [ADDR_W-1:0] lo_addr;
    logic [LANES-1:0]  keep_field;
    logic              unused_cmd_bits;

    assign lo_addr         = cmd[ADDR_W-1:0];
    assign keep_field      = cmd[KEEP_LSB +: LANES];
    assign unused_cmd_bits = ^{cmd[KEEP_LSB+LANES], cmd[KEEP_LSB-1]};

    always_comb begin
        op       = '0;
        op.core  = cmd[CORE_LSB +: CORE_W];
        case (send_kind_e'(kind))
            KIND_IRQ: begin
                op.launch    = 1'b1;
                op.need_read = 1'b0;
                op.addr      = SET_REG_ADDR;
                op.wdata     = vec_to_onehot(cmd[VEC_W-1:0]);
                op.keep      = '0;
            end
            KIND_MBOX: begin
                op.launch    = wide;
                op.keep      = keep_field;
                op.need_read = |keep_field;
                op.addr      = MBOX_BASE + (lo_addr & MBOX_SEL_BITS);
                op.wdata     = cmd[HI_LSB +: DATA_W];
            end
            KIND_FREE: begin
                op.launch    = wide;
                op.keep      = keep_field;
                op.need_read = |keep_field;
                op.addr      = lo_addr;
                op.wdata     = cmd[HI_LSB +: DATA_W];
            end
            default: begin
                op.launch    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
    import ipi_send_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  keep,
    output logic [DATA_W-1:0] merged
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign merged[ln*LANE_W +: LANE_W] = keep[ln] ? old_word[ln*LANE_W +: LANE_W]
                                                      : new_word[ln*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/ipi_bus_seq.sv
module ipi_bus_seq
    import ipi_send_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  send_op_t          op,
    input  logic              ack,
    input  logic [DATA_W-1:0] merged,
    output logic              busy,
    output logic              req,
    output logic              we,
    output logic [CORE_W-1:0] core_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  keep_q
);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            core_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            keep_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        core_q  <= op.core;
                        addr_q  <= op.addr;
                        wdata_q <= op.wdata;
                        keep_q  <= op.keep;
                        state   <= op.need_read ? SQ_READ : SQ_WRITE;
                    end
                end
                SQ_READ: begin
                    if (ack) begin
                        wdata_q <= merged;
                        state   <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (ack) begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign req  = (state != SQ_IDLE);
    assign we   = (state == SQ_WRITE);
    assign busy = req;

endmodule

// File: rtl/ipi_send_engine.sv
module ipi_send_engine
    import ipi_send_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_wide,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [CORE_W-1:0] bus_core,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    send_op_t          dec_op;
    logic              seq_busy;
    logic              seq_start;
    logic [DATA_W-1:0] merged_word;
    logic [LANES-1:0]  held_keep;

    ipi_cmd_decode u_decode (
        .kind (cmd_kind),
        .wide (cmd_wide),
        .cmd  (cmd_data),
        .op   (dec_op)
    );

    assign cmd_ready = !seq_busy;
    assign seq_start = cmd_valid && cmd_ready && dec_op.launch;

    ipi_byte_merge u_merge (
        .old_word (bus_rdata),
        .new_word (bus_wdata),
        .keep     (held_keep),
        .merged   (merged_word)
    );

    ipi_bus_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (seq_start),
        .op      (dec_op),
        .ack     (bus_ack),
        .merged  (merged_word),
        .busy    (seq_busy),
        .req     (bus_req),
        .we      (bus_we),
        .core_q  (bus_core),
        .addr_q  (bus_addr),
        .wdata_q (bus_wdata),
        .keep_q  (held_keep)
    );

endmodule

// File: rtl/ipi_send_engine_chk.sv
module ipi_send_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [1:0]  cmd_kind,
    input logic        cmd_wide,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_ack,
    input logic [9:0]  bus_core,
    input logic [15:0] bus_addr,
    input logic [31:0] bus_wdata
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            a_r12_reset_idle: assert (cmd_ready && !bus_req)
                else $error("reset state wrong");
        end
    end

    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
                                 && $stable(bus_core) && $stable(bus_wdata));

    a_r10_busy_during_req: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cmd_ready);

    a_r10_release_after_write: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && bus_ack |=> !bus_req && cmd_ready);

    a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we && bus_ack |=> bus_req && bus_we
                                          && $stable(bus_addr) && $stable(bus_core));

    a_r9_drop_reserved: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_kind == 2'd3 |=> !bus_req && cmd_ready);

    a_r8_drop_narrow: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_kind != 2'd0 && !cmd_wide |=> !bus_req && cmd_ready);

    a_r2_irq_single_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_kind == 2'd0 |=> bus_req && bus_we
            && bus_addr == 16'h1008 && $countones(bus_wdata) == 1);

endmodule

bind ipi_send_engine ipi_send_engine_chk u_chk (.*);

// File: tb/ipi_send_engine_test.sv
module ipi_send_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = 2'd0;
    logic        cmd_wide = 1'b0;
    logic [63:0] cmd_data = '0;
    logic        bus_req;
    logic        bus_we;
    logic [9:0]  bus_core;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ipi_send_engine uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_wide(cmd_wide), .cmd_data(cmd_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_core(bus_core),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [31:0] hi, input logic [3:0] keep,
                                       input logic [9:0] core, input logic [15:0] lo);
        return {hi, 1'b0, keep, 1'b0, core, lo};
    endfunction

    task automatic send(input logic [1:0] kind, input logic wide, input logic [63:0] d);
        @(negedge clk);
        chk("R10 ready before command", {63'd0, cmd_ready}, 64'd1);
        cmd_kind  = kind;
        cmd_wide  = wide;
        cmd_data  = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic serve(input string tag, input logic exp_we, input logic [15:0] exp_addr,
                         input logic [9:0] exp_core, input logic chk_wd,
                         input logic [31:0] exp_wd, input logic [31:0] rdata, input int stall);
        for (int i = 0; i < 20 && !bus_req; i++) @(negedge clk);
        chk({tag, " request present"}, {63'd0, bus_req}, 64'd1);
        chk({tag, " R6/R7 direction"}, {63'd0, bus_we}, {63'd0, exp_we});
        chk({tag, " address"}, {48'd0, bus_addr}, {48'd0, exp_addr});
        chk({tag, " R1 core"}, {54'd0, bus_core}, {54'd0, exp_core});
        chk({tag, " R10 busy"}, {63'd0, cmd_ready}, 64'd0);
        if (chk_wd) chk({tag, " R5 write data"}, {32'd0, bus_wdata}, {32'd0, exp_wd});
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk({tag, " R11 held req"}, {63'd0, bus_req}, 64'd1);
            chk({tag, " R11 held addr"}, {48'd0, bus_addr}, {48'd0, exp_addr});
            chk({tag, " R11 held we"}, {63'd0, bus_we}, {63'd0, exp_we});
            if (chk_wd) chk({tag, " R11 held data"}, {32'd0, bus_wdata}, {32'd0, exp_wd});
        end
        bus_rdata = rdata;
        bus_ack   = 1'b1;
        @(negedge clk);
        bus_ack   = 1'b0;
        bus_rdata = '0;
    endtask

    task automatic expect_idle(input string tag);
        chk({tag, " R10 ready after write"}, {63'd0, cmd_ready}, 64'd1);
        chk({tag, " R10 request dropped"}, {63'd0, bus_req}, 64'd0);
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            chk({tag, " no request"}, {63'd0, bus_req}, 64'd0);
            chk({tag, " still ready"}, {63'd0, cmd_ready}, 64'd1);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 ready after reset", {63'd0, cmd_ready}, 64'd1);
        chk("R12 no request after reset", {63'd0, bus_req}, 64'd0);
    endtask

    task automatic t_irq;
        send(2'd0, 1'b0, mk(32'hDEAD_BEEF, 4'hF, 10'h155, 16'h001F));
        serve("R2 irq vec31", 1'b1, 16'h1008, 10'h155, 1'b1, 32'h8000_0000, 32'h0, 0);
        expect_idle("R2 irq vec31");
        send(2'd0, 1'b1, mk(32'h0, 4'h0, 10'h001, 16'h0020));
        serve("R2 irq vec0", 1'b1, 16'h1008, 10'h001, 1'b1, 32'h0000_0001, 32'h0, 1);
        expect_idle("R2 irq vec0");
    endtask

    task automatic t_mbox_full;
        send(2'd1, 1'b1, mk(32'hCAFE_F00D, 4'h0, 10'h2A5, 16'h00F7));
        serve("R3 R7 mbox full", 1'b1, 16'h1034, 10'h2A5, 1'b1, 32'hCAFE_F00D, 32'h0, 0);
        expect_idle("R7 mbox full");
    endtask

    task automatic t_free_merge;
        send(2'd2, 1'b1, mk(32'hAABB_CCDD, 4'b0101, 10'h3FF, 16'h4460));
        serve("R4 R6 free read", 1'b0, 16'h4460, 10'h3FF, 1'b0, 32'h0, 32'h1122_3344, 3);
        serve("R5 free write", 1'b1, 16'h4460, 10'h3FF, 1'b1, 32'hAA22_CC44, 32'h0, 0);
        expect_idle("R5 free merge");
        send(2'd2, 1'b1, mk(32'h0102_0304, 4'b1010, 10'h0C3, 16'hFFFC));
        serve("R6 free read b", 1'b0, 16'hFFFC, 10'h0C3, 1'b0, 32'h0, 32'hF0E0_D0C0, 0);
        serve("R5 free write b", 1'b1, 16'hFFFC, 10'h0C3, 1'b1, 32'hF002_D004, 32'h0, 2);
        expect_idle("R5 free merge b");
    endtask

    task automatic t_mbox_keep_all;
        send(2'd1, 1'b1, mk(32'h1357_9BDF, 4'hF, 10'h000, 16'h0008));
        serve("R3 R6 mbox read", 1'b0, 16'h1028, 10'h000, 1'b0, 32'h0, 32'h5A5A_1234, 1);
        serve("R5 mbox keep all", 1'b1, 16'h1028, 10'h000, 1'b1, 32'h5A5A_1234, 32'h0, 0);
        expect_idle("R5 mbox keep all");
    endtask

    task automatic t_drop_narrow;
        send(2'd1, 1'b0, mk(32'h1111_1111, 4'h3, 10'h010, 16'h0004));
        expect_quiet("R8 narrow mbox", 4);
        send(2'd2, 1'b0, mk(32'h2222_2222, 4'h0, 10'h011, 16'h0100));
        expect_quiet("R8 narrow free", 4);
    endtask

    task automatic t_drop_rsvd;
        send(2'd3, 1'b1, mk(32'h3333_3333, 4'h1, 10'h012, 16'h1008));
        expect_quiet("R9 reserved kind", 4);
        send(2'd2, 1'b1, mk(32'h7777_8888, 4'h0, 10'h012, 16'h0040));
        serve("R9 alive after drop", 1'b1, 16'h0040, 10'h012, 1'b1, 32'h7777_8888, 32'h0, 0);
        expect_idle("R9 alive after drop");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_irq();
        t_mbox_full();
        t_free_merge();
        t_mbox_keep_all();
        t_drop_narrow();
        t_drop_rsvd();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule